// File: doc/BRIEF.md
# Leading-Zero Anticipator for Significand Subtraction

This block runs beside the significand subtractor of a floating-point adder. It receives two aligned significands and, without waiting for the difference, estimates how far the result will have to be shifted left to normalise it. The estimate is built from the operand bits alone. Each position is classified by comparing the minuend bit with the inverted subtrahend bit, which is the pair the adder itself sums. The result is a marker string in which each bit flags a candidate for the leading significant digit. A priority encoder turns the most significant marker into a shift count. Two more flags come out with it: one says the difference is negative and must be two's-complemented before the shift, and one says the operands are equal.

The estimate is exact or one short of the true leading-zero count of |A−B|. The normalising stage downstream fixes that last position, so it lives outside this block. Operand pairs arrive on a valid/ready stream and results leave on one. With the default output register a pair is accepted in every cycle in which the output slot is empty or is being drained, and its result appears one cycle later. While the consumer holds `out_ready` low, the result stays frozen and `in_ready` is low. With `REG_OUT = 0` the block is purely combinational and the two handshakes are wired straight through.

Top module: `lop_predictor`

## Requirements
- R1: `out_zero` is 1 exactly when the accepted operands are equal.
- R2: `out_neg` is 1 exactly when the accepted A is smaller than B (unsigned). It is 0 for equal operands.
- R3: For unequal operands, `out_lzc` equals the number of leading zeros of |A−B| in an N-bit field, or is one less.
- R4: `out_lzc` equals N−1−p, where p is the index of the highest set bit of `out_ind` (bit i marks significand bit i, with bit N−1 the most significant). When `out_ind` is all zero, `out_lzc` equals N.
- R5: For unequal operands, `out_ind` has at least one bit set.
- R6: With the output register, `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs hold their values into the next cycle.
- R7: With the output register, a pair accepted at a clock edge produces `out_valid` high at the next edge, with that pair's result. Pairs can be accepted on consecutive cycles.
- R8: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair |
| in_a | input | N | Minuend significand |
| in_b | input | N | Subtrahend significand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ind | output | N | Leading-digit marker string |
| out_lzc | output | clog2(N+1) | Predicted leading-zero count |
| out_neg | output | 1 | Difference is negative |
| out_zero | output | 1 | Operands are equal |

## Verification
Directed pairs cover the cases where the estimate is most likely to slip:
- a borrow that ripples across the whole field (a power of two minus one less), which separates the exact count from the one-short case;
- differences of ±1 and ±2, which reach the deepest counts;
- all-ones against zero in both orders, which puts the leading digit at the top;
- equal pairs, which must raise the zero flag and give an empty marker string.

Random pairs then mix both signs at random distances, and random consumer stalls test that results are held and that nothing is lost or repeated. The bench compares every output with an exact integer leading-zero count of the magnitude, so off-by-one errors in either direction are caught.

// File: rtl/lop_pkg.sv
package lop_pkg;
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lop_classify.sv
module lop_classify #(
  parameter int N = 27
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] pt,
  output logic [N-1:0] pg,
  output logic [N-1:0] pz
);
  logic [N-1:0] bn;
  assign bn = ~b;
  assign pt = a ^ bn;
  assign pg = a & bn;
  assign pz = ~a & ~bn;
endmodule

// File: rtl/lop_indicator.sv
module lop_indicator #(
  parameter int N = 27
) (
  input  logic [N-1:0] pt,
  input  logic [N-1:0] pg,
  input  logic [N-1:0] pz,
  output logic [N-1:0] ind
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic t_up, z_dn, g_dn;
    if (i == N - 1) begin : g_top
      assign t_up = 1'b1;
    end else begin : g_mid
      assign t_up = pt[i+1];
    end
    if (i == 0) begin : g_low
      assign z_dn = 1'b0;
      assign g_dn = 1'b0;
    end else begin : g_rest
      assign z_dn = pz[i-1];
      assign g_dn = pg[i-1];
    end
    assign ind[i] = t_up  ? ((pg[i] & ~z_dn) | (pz[i] & ~g_dn))
                          : ((pz[i] & ~z_dn) | (pg[i] & ~g_dn));
  end
endmodule

// File: rtl/lop_encode.sv
module lop_encode #(
  parameter int N  = 27,
  parameter int CW = 5
) (
  input  logic [N-1:0]  ind,
  input  logic [N-1:0]  pt,
  input  logic [N-1:0]  pz,
  output logic [CW-1:0] cnt,
  output logic          neg,
  output logic          zero
);
  always_comb begin
    cnt = CW'(N);
    for (int i = 0; i < N; i++) begin
      if (ind[i]) cnt = CW'(N - 1 - i);
    end
  end

  always_comb begin
    neg = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!pt[i]) neg = pz[i];
    end
  end

  assign zero = &pt;
endmodule

// File: rtl/lop_predictor.sv
module lop_predictor
  import lop_pkg::*;
#(
  parameter int N       = 27,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = cnt_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_a,
  input  logic [N-1:0]  in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N-1:0]  out_ind,
  output logic [CW-1:0] out_lzc,
  output logic          out_neg,
  output logic          out_zero
);
  logic [N-1:0]  pt, pg, pz, ind_c;
  logic [CW-1:0] cnt_c;
  logic          neg_c, zero_c;

  lop_classify #(.N(N)) u_cls (
    .a(in_a), .b(in_b), .pt(pt), .pg(pg), .pz(pz)
  );

  lop_indicator #(.N(N)) u_ind (
    .pt(pt), .pg(pg), .pz(pz), .ind(ind_c)
  );

  lop_encode #(.N(N), .CW(CW)) u_enc (
    .ind(ind_c), .pt(pt), .pz(pz), .cnt(cnt_c), .neg(neg_c), .zero(zero_c)
  );

  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [N-1:0]  ind_q;
    logic [CW-1:0] cnt_q;
    logic          neg_q, zero_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        ind_q  <= '0;
        cnt_q  <= '0;
        neg_q  <= 1'b0;
        zero_q <= 1'b0;
      end else if (in_ready) begin
        vld_q  <= in_valid;
        ind_q  <= ind_c;
        cnt_q  <= cnt_c;
        neg_q  <= neg_c;
        zero_q <= zero_c;
      end
    end

    assign out_valid = vld_q;
    assign out_ind   = ind_q;
    assign out_lzc   = cnt_q;
    assign out_neg   = neg_q;
    assign out_zero  = zero_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_ind   = ind_c;
    assign out_lzc   = cnt_c;
    assign out_neg   = neg_c;
    assign out_zero  = zero_c;
  end
endmodule

// File: rtl/lop_predictor_chk.sv
module lop_predictor_chk #(
  parameter int N       = 27,
  parameter bit REG_OUT = 1'b1,
  parameter int CW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  in_a,
  input logic [N-1:0]  in_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [N-1:0]  out_ind,
  input logic [CW-1:0] out_lzc,
  input logic          out_neg,
  input logic          out_zero
);
  if (REG_OUT) begin : g_seq
    // R7
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_ind) &&
        $stable(out_lzc) && $stable(out_neg) && $stable(out_zero));
    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_zero == $past(in_a == in_b));
    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_neg == $past(in_a < in_b));
  end else begin : g_cmb
    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_zero == (in_a == in_b));
    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_neg == (in_a < in_b));
  end
  // R5
  ind_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> out_ind != '0);
  // R4
  empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ind == '0 |-> out_lzc == CW'(N));
endmodule

bind lop_predictor lop_predictor_chk #(.N(N), .REG_OUT(REG_OUT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_ind(out_ind), .out_lzc(out_lzc), .out_neg(out_neg), .out_zero(out_zero)
);

// File: tb/sim_lop_predictor.sv
`timescale 1ns/1ps
module sim_lop_predictor;
  localparam int N  = 27;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [N-1:0]  in_a = '0, in_b = '0;
  logic          in_ready, out_valid, out_neg, out_zero;
  logic [N-1:0]  out_ind;
  logic [CW-1:0] out_lzc;

  int checks = 0, failures = 0, cycles = 0;
  logic         m_valid = 1'b0;
  logic [N-1:0] m_a = '0, m_b = '0;
  logic [N-1:0] da[$], db[$];

  always #10 clk = ~clk;

  lop_predictor #(.N(N), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_ind(out_ind), .out_lzc(out_lzc), .out_neg(out_neg), .out_zero(out_zero)
  );

  // behavioural model of the one-slot output stage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (!m_valid || out_ready) begin
      m_valid <= in_valid;
      m_a     <= in_a;
      m_b     <= in_b;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int true_lz(input logic [N-1:0] a, input logic [N-1:0] b);
    longint d = longint'(a) - longint'(b);
    longint m = (d < 0) ? -d : d;
    int z = N;
    for (int i = 0; i < N; i++) if (m[i]) z = N - 1 - i;
    return z;
  endfunction

  function automatic int ind_count(input logic [N-1:0] v);
    int z = N;
    for (int i = 0; i < N; i++) if (v[i]) z = N - 1 - i;
    return z;
  endfunction

  task automatic compare();
    int tl;
    chk(out_valid == m_valid, "R7 out_valid", out_valid, m_valid);
    chk(in_ready == (!m_valid || out_ready), "R6 in_ready", in_ready, !m_valid || out_ready);
    if (m_valid) begin
      chk(out_zero == (m_a == m_b), "R1 zero", out_zero, m_a == m_b);
      chk(out_neg == (m_a < m_b), "R2 neg", out_neg, m_a < m_b);
      chk(int'(out_lzc) == ind_count(out_ind), "R4 count vs marker", out_lzc, ind_count(out_ind));
      if (m_a != m_b) begin
        tl = true_lz(m_a, m_b);
        chk(int'(out_lzc) == tl || int'(out_lzc) == tl - 1, "R3 count bound", out_lzc, tl);
        chk(out_ind != '0, "R5 marker present", out_ind, 1);
      end
    end
  endtask

  initial begin
    logic [N-1:0] allones;
    allones = '1;
    da.push_back(N'(1) << (N-1)); db.push_back((N'(1) << (N-1)) - 1);
    da.push_back((N'(1) << (N-1)) - 1); db.push_back(N'(1) << (N-1));
    da.push_back(N'(5)); db.push_back(N'(4));
    da.push_back(N'(4)); db.push_back(N'(5));
    da.push_back(N'(6)); db.push_back(N'(4));
    da.push_back(N'(3)); db.push_back(N'(5));
    da.push_back(allones); db.push_back('0);
    da.push_back('0); db.push_back(allones);
    da.push_back(N'(12345)); db.push_back(N'(12345));
    da.push_back('0); db.push_back('0);
    da.push_back(N'(1) << 20); db.push_back(N'(3) << 18);
    da.push_back(N'(1) << 10); db.push_back(N'(1) << 12);

    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 reset idle", out_valid, 0);
    end
    rst_n = 1'b1;
    out_ready = 1'b1;

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      compare();
      if (!(in_valid && !in_ready)) begin
        if (da.size() > 0) begin
          in_valid = 1'b1;
          in_a = da.pop_front();
          in_b = db.pop_front();
        end else begin
          in_valid = ($urandom_range(0, 3) != 0);
          in_a = N'($urandom);
          in_b = ($urandom_range(0, 7) == 0) ? in_a : N'($urandom) >> $urandom_range(0, N-1);
          if ($urandom_range(0, 1) == 1) begin
            logic [N-1:0] tmp;
            tmp = in_a; in_a = in_b; in_b = tmp;
          end
        end
      end
      out_ready = (k < 40) ? 1'b1 : ($urandom_range(0, 3) != 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule